// File: doc/BRIEF.md
# RMII Transmit Di-bit Serializer

This block sits on the MAC side of a reduced media-independent interface and converts a byte-wide frame stream into the 2-bit transmit symbols that a 100 Mb/s PHY expects. It runs entirely on the 50 MHz reference clock. One di-bit leaves the block on every clock while the transmit enable output is high.

An upstream source requests a frame by presenting its first payload byte with valid and start-of-frame flags. The block then produces the preamble and the start delimiter on its own, without consuming anything. After that it pulls payload bytes one at a time through a single-cycle ready pulse and shifts each byte out as four di-bits, low-order pair first. The frame closes after the byte marked end-of-frame. If the source has no byte at a ready pulse, the frame is cut short and a sticky underrun flag is set. Between frames the block keeps transmit enable low for a minimum interframe gap.

Top module: `rmii_tx_serializer`

## Requirements
- R1: While reset is held low, and after it is released, `tx_en` is 0, `txd` is 2'b00, `in_ready` is 0 and `underrun_flag` is 0. Reset takes effect asynchronously, even in the middle of a frame. `txd` is 2'b00 in every cycle in which `tx_en` is 0.
- R2: When the block is idle and the gap of R8 has elapsed, a clock edge that sees `in_valid` and `in_sof` both at 1 raises `tx_en` and at the same edge presents the first preamble di-bit, 2'b01. This request does not consume the byte.
- R3: Every frame starts with 28 di-bits of 2'b01, which are seven 0x55 bytes. These are followed by the delimiter di-bits 2'b01, 2'b01, 2'b01, 2'b11, which is the byte 0xD5. Only after that does the first payload di-bit appear.
- R4: Each payload byte takes four consecutive clocks, in the order `in_data[1:0]`, `[3:2]`, `[5:4]`, `[7:6]`.
- R5: `in_ready` is 1 for exactly one clock, during the last delimiter di-bit and during the last di-bit of each payload byte that is not marked end-of-frame. It is never 1 while `tx_en` is 0. A byte is taken at the edge that ends such a cycle, if `in_valid` is 1. Its `in_eof` bit marks it as the final byte.
- R6: `tx_en` stays 1 without a gap from the first preamble di-bit to the last di-bit of the final byte. It drops at the next edge. A frame of N payload bytes therefore holds `tx_en` high for 32+4N clocks.
- R7: If `in_valid` is 0 during a ready cycle, the frame ends after the di-bit that is currently being sent, and `underrun_flag` becomes 1. The flag stays at 1 through later frames until reset.
- R8: After a frame ends, `tx_en` stays 0 for at least 48 clocks. A request held from the end of the frame starts the next frame after exactly 48 idle clocks.
- R9: While idle, `in_valid` without `in_sof` starts no frame and raises no `in_ready`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ref | input | 1 | 50 MHz reference clock |
| rst_n | input | 1 | Active-low reset, asynchronous assert |
| in_data | input | 8 | Payload byte from upstream |
| in_valid | input | 1 | `in_data` and the flags are meaningful |
| in_sof | input | 1 | Byte is the first of a frame |
| in_eof | input | 1 | Byte is the last of a frame |
| in_ready | output | 1 | Byte is taken at this clock edge when valid |
| tx_en | output | 1 | Transmit enable toward the PHY |
| txd | output | 2 | Transmit di-bit toward the PHY |
| underrun_flag | output | 1 | Sticky: a frame was cut short for lack of data |

## Verification
The assertions assume that upstream changes its byte and flags only after an edge at which `in_ready` was high, and that it never marks a byte both end-of-frame and underrun-prone in the same cycle. The driver updates its inputs just after the consuming edge and keeps the first byte stable from the request until the delimiter's ready pulse. The bench checks the 48-clock gap rule with a request held from the moment the previous frame ends, so every measured gap should be exactly the minimum. Underrun is provoked only at a ready cycle, because that is the only place where the block samples `in_valid` mid-frame.

// File: rtl/rmii_tx_pkg.sv
package rmii_tx_pkg;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_PRE  = 2'd1,
    PH_SFD  = 2'd2,
    PH_DATA = 2'd3
  } tx_phase_e;

  localparam logic [7:0] PREAMBLE_PATTERN = 8'h55;
  localparam logic [7:0] DELIM_PATTERN    = 8'hD5;

endpackage

// File: rtl/rmii_tx_ifg_timer.sv
module rmii_tx_ifg_timer #(
  parameter int GAP_CYCLES = 48
) (
  input  logic clk,
  input  logic rst_n,
  input  logic busy,
  output logic gap_ok
);
  localparam int CW = (GAP_CYCLES > 1) ? $clog2(GAP_CYCLES) : 1;
  localparam logic [CW-1:0] LIMIT = CW'(GAP_CYCLES - 1);

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (busy) begin
      cnt_d = '0;
    end else if (cnt_q != LIMIT) begin
      cnt_d = cnt_q + CW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= LIMIT;
    end else begin
      cnt_q <= cnt_d;
    end
  end

  assign gap_ok = (cnt_q == LIMIT);

endmodule

// File: rtl/rmii_tx_dibit_shifter.sv
module rmii_tx_dibit_shifter #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [DATA_W-1:0] load_byte,
  input  logic              shift_en,
  output logic [1:0]        dibit
);
  logic [DATA_W-1:0] sh_q, sh_d;

  always_comb begin
    sh_d = sh_q;
    if (load) begin
      sh_d = load_byte;
    end else if (shift_en) begin
      sh_d = sh_q >> 2;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q <= '0;
    end else begin
      sh_q <= sh_d;
    end
  end

  assign dibit = sh_q[1:0];

endmodule

// File: rtl/rmii_tx_frame_fsm.sv
module rmii_tx_frame_fsm
  import rmii_tx_pkg::*;
#(
  parameter int                PREAMBLE_BYTES = 7,
  parameter int                DATA_W         = 8,
  parameter logic [DATA_W-1:0] PRE_PATTERN    = PREAMBLE_PATTERN,
  parameter logic [DATA_W-1:0] SFD_PATTERN    = DELIM_PATTERN
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              gap_ok,
  input  logic [DATA_W-1:0] in_data,
  input  logic              in_valid,
  input  logic              in_sof,
  input  logic              in_eof,
  output logic              in_ready,
  output logic              active,
  output logic              load,
  output logic [DATA_W-1:0] load_byte,
  output logic              shift_en,
  output logic              underrun_flag
);
  localparam int DIBITS = DATA_W / 2;
  localparam int DC_W   = (DIBITS > 1) ? $clog2(DIBITS) : 1;
  localparam int PC_W   = $clog2(PREAMBLE_BYTES + 1);
  localparam logic [DC_W-1:0] DC_LAST = DC_W'(DIBITS - 1);
  localparam logic [PC_W-1:0] PC_LAST = PC_W'(PREAMBLE_BYTES - 1);

  tx_phase_e       phase_q, phase_d;
  logic [DC_W-1:0] dcnt_q, dcnt_d;
  logic [PC_W-1:0] pcnt_q, pcnt_d;
  logic            last_q, last_d;
  logic            urun_q, urun_d;
  logic            byte_end;

  assign byte_end = (dcnt_q == DC_LAST);

  always_comb begin
    phase_d   = phase_q;
    dcnt_d    = dcnt_q;
    pcnt_d    = pcnt_q;
    last_d    = last_q;
    urun_d    = urun_q;
    load      = 1'b0;
    load_byte = '0;
    shift_en  = 1'b0;
    in_ready  = 1'b0;
    case (phase_q)
      PH_IDLE: begin
        if (gap_ok && in_valid && in_sof) begin
          phase_d   = PH_PRE;
          dcnt_d    = '0;
          pcnt_d    = '0;
          last_d    = 1'b0;
          load      = 1'b1;
          load_byte = PRE_PATTERN;
        end
      end
      PH_PRE: begin
        if (byte_end) begin
          dcnt_d = '0;
          load   = 1'b1;
          if (pcnt_q == PC_LAST) begin
            phase_d   = PH_SFD;
            load_byte = SFD_PATTERN;
          end else begin
            pcnt_d    = pcnt_q + PC_W'(1);
            load_byte = PRE_PATTERN;
          end
        end else begin
          dcnt_d   = dcnt_q + DC_W'(1);
          shift_en = 1'b1;
        end
      end
      default: begin
        if (byte_end) begin
          dcnt_d = '0;
          if (phase_q == PH_DATA && last_q) begin
            phase_d = PH_IDLE;
          end else begin
            in_ready = 1'b1;
            if (in_valid) begin
              phase_d   = PH_DATA;
              load      = 1'b1;
              load_byte = in_data;
              last_d    = in_eof;
            end else begin
              phase_d = PH_IDLE;
              urun_d  = 1'b1;
            end
          end
        end else begin
          dcnt_d   = dcnt_q + DC_W'(1);
          shift_en = 1'b1;
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      dcnt_q  <= '0;
      pcnt_q  <= '0;
      last_q  <= 1'b0;
      urun_q  <= 1'b0;
    end else begin
      phase_q <= phase_d;
      dcnt_q  <= dcnt_d;
      pcnt_q  <= pcnt_d;
      last_q  <= last_d;
      urun_q  <= urun_d;
    end
  end

  assign active        = (phase_q != PH_IDLE);
  assign underrun_flag = urun_q;

  // R5
  ready_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |=> !in_ready);

  // R5
  ready_inside_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> active);

  // R6
  release_on_boundary_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(active) |-> $past(byte_end));

  // R7
  underrun_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    urun_q |=> urun_q);

endmodule

// File: rtl/rmii_tx_serializer.sv
module rmii_tx_serializer
  import rmii_tx_pkg::*;
#(
  parameter int DATA_W         = 8,
  parameter int PREAMBLE_BYTES = 7,
  parameter int GAP_CYCLES     = 48
) (
  input  logic              clk_ref,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] in_data,
  input  logic              in_valid,
  input  logic              in_sof,
  input  logic              in_eof,
  output logic              in_ready,
  output logic              tx_en,
  output logic [1:0]        txd,
  output logic              underrun_flag
);
  localparam logic [DATA_W-1:0] PRE_W = DATA_W'(PREAMBLE_PATTERN);
  localparam logic [DATA_W-1:0] SFD_W = DATA_W'(DELIM_PATTERN);

  logic              gap_ok;
  logic              active;
  logic              load;
  logic [DATA_W-1:0] load_byte;
  logic              shift_en;
  logic [1:0]        dibit;

  rmii_tx_ifg_timer #(
    .GAP_CYCLES(GAP_CYCLES)
  ) ifg_i (
    .clk    (clk_ref),
    .rst_n  (rst_n),
    .busy   (active),
    .gap_ok (gap_ok)
  );

  rmii_tx_frame_fsm #(
    .PREAMBLE_BYTES(PREAMBLE_BYTES),
    .DATA_W        (DATA_W),
    .PRE_PATTERN   (PRE_W),
    .SFD_PATTERN   (SFD_W)
  ) fsm_i (
    .clk           (clk_ref),
    .rst_n         (rst_n),
    .gap_ok        (gap_ok),
    .in_data       (in_data),
    .in_valid      (in_valid),
    .in_sof        (in_sof),
    .in_eof        (in_eof),
    .in_ready      (in_ready),
    .active        (active),
    .load          (load),
    .load_byte     (load_byte),
    .shift_en      (shift_en),
    .underrun_flag (underrun_flag)
  );

  rmii_tx_dibit_shifter #(
    .DATA_W(DATA_W)
  ) shift_i (
    .clk       (clk_ref),
    .rst_n     (rst_n),
    .load      (load),
    .load_byte (load_byte),
    .shift_en  (shift_en),
    .dibit     (dibit)
  );

  assign tx_en = active;
  assign txd   = active ? dibit : 2'b00;

  // R8
  gap_before_start_chk: assert property (@(posedge clk_ref) disable iff (!rst_n)
    $rose(tx_en) |-> $past(gap_ok));

  // R2
  first_preamble_dibit_chk: assert property (@(posedge clk_ref) disable iff (!rst_n)
    $rose(tx_en) |-> (txd == PRE_W[1:0]));

endmodule

// File: tb/rmii_tx_serializer_tb_top.sv
module rmii_tx_serializer_tb_top;
  localparam int CLK_PERIOD = 20;
  localparam int NVEC = 5;
  // {payload length, bytes 3..0}; byte k sits at bits [8k+7:8k]
  localparam logic [35:0] VEC [NVEC] = '{
    {4'd1, 32'h0000_00A5},
    {4'd2, 32'h0000_3CFF},
    {4'd4, 32'hDEAD_BEEF},
    {4'd3, 32'h0012_C381},
    {4'd4, 32'h0055_D500}
  };

  logic       clk_ref = 1'b0;
  logic       rst_n;
  logic [7:0] in_data;
  logic       in_valid, in_sof, in_eof;
  logic       in_ready, tx_en, underrun_flag;
  logic [1:0] txd;

  int tests = 0;
  int fails = 0;

  rmii_tx_serializer dut_i (
    .clk_ref       (clk_ref),
    .rst_n         (rst_n),
    .in_data       (in_data),
    .in_valid      (in_valid),
    .in_sof        (in_sof),
    .in_eof        (in_eof),
    .in_ready      (in_ready),
    .tx_en         (tx_en),
    .txd           (txd),
    .underrun_flag (underrun_flag)
  );

  always #(CLK_PERIOD/2) clk_ref = ~clk_ref;

  // monitor, sampled at the falling edge
  logic [1:0] cap [64];
  int cap_n = 0;
  int rises = 0;
  int idle_run = 1000;
  int last_gap = 0;
  int bad_idle = 0;
  int bad_rdy = 0;
  logic prev_en = 1'b0;

  always @(negedge clk_ref) begin
    if (!tx_en) begin
      idle_run = idle_run + 1;
      if (txd != 2'b00) bad_idle = bad_idle + 1;
      if (in_ready) bad_rdy = bad_rdy + 1;
    end else begin
      if (!prev_en) begin
        last_gap = idle_run;
        idle_run = 0;
        rises = rises + 1;
        cap_n = 0;
      end
      if (cap_n < 64) cap[cap_n] = txd;
      cap_n = cap_n + 1;
    end
    prev_en = tx_en;
  end

  task automatic check(input string req, input logic ok, input int act, input int exp);
    tests = tests + 1;
    if (!ok) begin
      fails = fails + 1;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic logic [1:0] exp_dibit(input int idx, input logic [31:0] bytes);
    int b;
    int d;
    if (idx < 31) return 2'b01;
    if (idx == 31) return 2'b11;
    b = (idx - 32) / 4;
    d = (idx - 32) % 4;
    return bytes[b*8 + d*2 +: 2];
  endfunction

  // send n bytes; only the first 'give' are offered, then valid drops
  task automatic send_frame(input logic [31:0] bytes, input int n, input int give);
    int i = 0;
    in_data  = bytes[7:0];
    in_sof   = 1'b1;
    in_eof   = (n == 1);
    in_valid = 1'b1;
    while (i < give) begin
      @(negedge clk_ref);
      if (in_ready) begin
        @(posedge clk_ref);
        #1;
        i = i + 1;
        in_sof = 1'b0;
        if (i < give) begin
          in_data = bytes[i*8 +: 8];
          in_eof  = (i == n - 1);
        end else begin
          in_valid = 1'b0;
          in_eof   = 1'b0;
          in_data  = 8'h00;
        end
      end
    end
    @(negedge clk_ref);
    while (tx_en) @(negedge clk_ref);
  endtask

  task automatic check_content(input string req, input logic [31:0] bytes, input int len);
    int bad = 0;
    int first_bad = -1;
    for (int k = 0; k < len; k++) begin
      if (cap[k] != exp_dibit(k, bytes)) begin
        bad = bad + 1;
        if (first_bad < 0) first_bad = k;
      end
    end
    if (first_bad < 0) first_bad = 0;
    check(req, bad == 0, int'(cap[first_bad]), int'(exp_dibit(first_bad, bytes)));
  endtask

  initial begin
    repeat (150000) @(posedge clk_ref);
    fails = fails + 1;
    tests = tests + 1;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [31:0] bytes;
    int n;
    int r0;
    rst_n = 1'b0;
    in_data = 8'h00; in_valid = 1'b0; in_sof = 1'b0; in_eof = 1'b0;
    repeat (3) @(negedge clk_ref);
    // R1: reset state
    check("R1 tx_en in reset", tx_en == 1'b0, int'(tx_en), 0);
    check("R1 txd in reset", txd == 2'b00, int'(txd), 0);
    rst_n = 1'b1;
    @(negedge clk_ref);
    check("R1 in_ready after reset", in_ready == 1'b0, int'(in_ready), 0);
    check("R1 underrun after reset", underrun_flag == 1'b0, int'(underrun_flag), 0);

    // table walk: R2 R3 R4 R5 R6 R8
    for (int k = 0; k < NVEC; k++) begin
      bytes = VEC[k][31:0];
      n = int'(VEC[k][35:32]);
      r0 = rises;
      send_frame(bytes, n, n);
      check("R6 one contiguous burst", rises == r0 + 1, rises - r0, 1);
      check("R6 burst length", cap_n == 32 + 4*n, cap_n, 32 + 4*n);
      check_content("R3 R4 di-bit sequence", bytes, 32 + 4*n);
      if (k > 0) check("R8 interframe gap", last_gap == 48, last_gap, 48);
      check("R7 no underrun on full frame", underrun_flag == 1'b0, int'(underrun_flag), 0);
    end

    // R9: valid without sof is ignored
    repeat (60) @(negedge clk_ref);
    r0 = rises;
    in_data = 8'h77; in_valid = 1'b1; in_sof = 1'b0; in_eof = 1'b1;
    repeat (80) @(negedge clk_ref);
    check("R9 no frame without sof", rises == r0 && !tx_en, rises - r0, 0);
    in_valid = 1'b0; in_eof = 1'b0;

    // R7: underrun after the first byte of a three-byte frame
    bytes = 32'h0033_2211;
    send_frame(bytes, 3, 1);
    check("R7 frame cut after one byte", cap_n == 36, cap_n, 36);
    check_content("R7 di-bits before cut", bytes, 36);
    check("R7 underrun flag set", underrun_flag == 1'b1, int'(underrun_flag), 1);

    // R7: flag stays set through a later good frame
    send_frame(32'h0000_0042, 1, 1);
    check("R7 flag sticky", underrun_flag == 1'b1, int'(underrun_flag), 1);
    check("R8 gap after underrun frame", last_gap == 48, last_gap, 48);

    // R1: reset in the middle of a frame
    in_data = 8'h99; in_sof = 1'b1; in_eof = 1'b1; in_valid = 1'b1;
    repeat (60) @(negedge clk_ref);
    check("R2 frame running before reset", tx_en == 1'b1, int'(tx_en), 1);
    #2 rst_n = 1'b0;
    #1;
    check("R1 async tx_en clear", tx_en == 1'b0 && txd == 2'b00, int'(tx_en), 0);
    check("R1 async flag clear", underrun_flag == 1'b0, int'(underrun_flag), 0);
    in_valid = 1'b0; in_sof = 1'b0; in_eof = 1'b0;
    @(negedge clk_ref);
    rst_n = 1'b1;
    repeat (5) @(negedge clk_ref);

    // R1 R5: global monitor results
    check("R1 txd idle encoding", bad_idle == 0, bad_idle, 0);
    check("R5 no ready while idle", bad_rdy == 0, bad_rdy, 0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule